// File: doc/BRIEF.md
# Multichannel Sample Scan Streamer

This block pushes conversion results out of a serial data pin without any read command. Each time a strobe reports that a fresh set of results is valid, the block captures all channel samples in one step. It drives its active-low conversion-done flag low and presents the most significant bit of the lowest-numbered enabled channel at once. An external master then clocks the data out with a serial clock that is synchronous to the system clock. The block sends each enabled channel MSB-first, in ascending channel order, and leaves disabled channels out of the stream.

The master may raise chip select between bits or between channels. The block keeps its place in the stream while chip select is high. If the master supplies too few clocks, the stream is cut short. A one-cycle early-warning input releases the done flag before the next result set arrives. When the channel mask is all zero, the block is in ordinary read mode: a read request loads a register word supplied from outside, and the block shifts that word out the same way. While any channel is enabled, read requests are ignored.

Top module: `adc_scan_streamer`

## Requirements
- R1: After reset, `eoc_n` is 1 and `sdo` is 0, and serial clocks alone do not change either output.
- R2: When `res_valid` is high at a clock edge and `chan_en` is nonzero, then after that edge `eoc_n` is 0 and `sdo` shows bit 15 of the lowest-numbered enabled channel. Channel k is taken from bits `[16k+15:16k]` of `samples`.
- R3: Each rising edge of `sclk` that is seen while `cs_n` is low moves the stream on by one bit, in the system-clock cycle where `sclk` is first sampled high. Bits are sent MSB-first, 16 per channel.
- R4: Enabled channels follow one another in ascending index order (bit 0 of `chan_en` is channel A). A channel whose enable bit is 0 puts no bits into the stream.
- R5: Rising edges of `sclk` while `cs_n` is high do not move the stream. The bit and channel position are kept for when `cs_n` falls again.
- R6: The `sclk` rise that shifts out the last bit of the last enabled channel ends the frame: `eoc_n` goes to 1 and `sdo` goes to 0 after that edge.
- R7: `pre_ready` high at an edge, without `res_valid`, sets `eoc_n` to 1 after that edge. Shifting of the current frame carries on.
- R8: With `chan_en` all zero, `res_valid` is ignored: `eoc_n` stays 1 and `sdo` stays 0.
- R9: A `res_valid` that arrives during a frame abandons that frame and starts the new set at its first enabled channel. This wins over an `sclk` rise in the same cycle.
- R10: With `chan_en` all zero and no transfer running, `rd_req` loads `rd_word`, which is then shifted out MSB-first like a channel. `eoc_n` stays 1 throughout, and `sdo` returns to 0 after 16 bits.
- R11: `rd_req` while `chan_en` is nonzero has no effect. `sdo` stays 0 when the block is idle.
- R12: When `res_valid` and `pre_ready` are both high in the same cycle with a nonzero mask, the new frame wins: `eoc_n` is 0 after the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en | input | 4 | Per-channel automatic output enable, bit 0 = channel A |
| samples | input | 64 | Conversion results, channel k in bits 16k+15:16k |
| res_valid | input | 1 | One-cycle strobe: a new result set is valid |
| pre_ready | input | 1 | One-cycle warning that the next result set is one clock away |
| sclk | input | 1 | Serial clock, sampled on clk |
| cs_n | input | 1 | Active-low chip select |
| rd_req | input | 1 | Read request decoded from the serial input |
| rd_word | input | 16 | Register word to send for a read request |
| sdo | output | 1 | Serial data output |
| eoc_n | output | 1 | Active-low conversion-done flag |

## Verification
Two things can land in the same system-clock cycle. One is a new result set arriving while an `sclk` rise is due to shift the old frame. The other is the early-warning release of the done flag arriving together with a new result set. The bench drives `res_valid` high on the same edge as an `sclk` rise in the middle of a frame. It then checks that `sdo` shows the new set's first MSB, that `eoc_n` is low, and that the following bits come from the new set with no bit of the old frame left over. It also raises `res_valid` and `pre_ready` together and expects `eoc_n` low with the first channel's MSB on `sdo`.

// File: rtl/scan_pkg.sv
package scan_pkg;
    localparam int unsigned NUM_CH_DEF  = 4;
    localparam int unsigned SAMPLE_W_DEF = 16;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_SCAN = 2'd1,
        MODE_READ = 2'd2
    } stream_mode_e;
endpackage

// File: rtl/scan_sclk_edge.sv
module scan_sclk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    output logic sclk_rise
);
    logic sclk_d, sclk_q;

    always_comb begin
        sclk_d    = sclk;
        sclk_rise = sclk & ~sclk_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_d;
    end
endmodule

// File: rtl/scan_chan_pick.sv
module scan_chan_pick #(
    parameter int unsigned NUM_CH = 4,
    localparam int unsigned CW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [NUM_CH-1:0] mask,
    input  logic [CW:0]       start,
    output logic              found,
    output logic [CW-1:0]     idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (mask[i] && ((CW+1)'(i) >= start)) begin
                found = 1'b1;
                idx   = CW'(i);
            end
        end
    end
endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
    import scan_pkg::*;
#(
    parameter int unsigned NUM_CH   = 4,
    parameter int unsigned SAMPLE_W = 16,
    localparam int unsigned CW      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int unsigned BCW     = $clog2(SAMPLE_W),
    localparam int unsigned BANK_W  = NUM_CH * SAMPLE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_CH-1:0]   chan_en,
    input  logic [BANK_W-1:0]   samples,
    input  logic                res_valid,
    input  logic                pre_ready,
    input  logic                sclk_rise,
    input  logic                cs_n,
    input  logic                rd_req,
    input  logic [SAMPLE_W-1:0] rd_word,
    output logic                sdo,
    output logic                eoc_n
);
    localparam logic [BCW-1:0] LAST_BIT = BCW'(SAMPLE_W - 1);

    typedef struct packed {
        stream_mode_e          mode;
        logic                  eoc_n;
        logic [CW-1:0]         ch;
        logic [BCW-1:0]        bitcnt;
        logic [SAMPLE_W-1:0]   shreg;
        logic [BANK_W-1:0]     bank;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic          first_found, next_found;
    logic [CW-1:0] first_idx, next_idx;
    logic [CW:0]   next_start;
    logic          scan_on;

    assign scan_on    = |chan_en;
    assign next_start = {1'b0, st_q.ch} + (CW+1)'(1);

    scan_chan_pick #(.NUM_CH(NUM_CH)) u_pick_first (
        .mask  (chan_en),
        .start ('0),
        .found (first_found),
        .idx   (first_idx)
    );

    scan_chan_pick #(.NUM_CH(NUM_CH)) u_pick_next (
        .mask  (chan_en),
        .start (next_start),
        .found (next_found),
        .idx   (next_idx)
    );

    always_comb begin
        st_d = st_q;
        if (res_valid && scan_on && first_found) begin
            // new result set: capture, restart at first enabled channel
            st_d.bank   = samples;
            st_d.mode   = MODE_SCAN;
            st_d.ch     = first_idx;
            st_d.bitcnt = LAST_BIT;
            st_d.shreg  = samples[first_idx*SAMPLE_W +: SAMPLE_W];
            st_d.eoc_n  = 1'b0;
        end else begin
            if (rd_req && !scan_on && (st_q.mode == MODE_IDLE)) begin
                st_d.mode   = MODE_READ;
                st_d.bitcnt = LAST_BIT;
                st_d.shreg  = rd_word;
            end else if (sclk_rise && !cs_n && (st_q.mode != MODE_IDLE)) begin
                if (st_q.bitcnt != '0) begin
                    st_d.shreg  = {st_q.shreg[SAMPLE_W-2:0], 1'b0};
                    st_d.bitcnt = st_q.bitcnt - BCW'(1);
                end else if ((st_q.mode == MODE_SCAN) && next_found) begin
                    st_d.ch     = next_idx;
                    st_d.bitcnt = LAST_BIT;
                    st_d.shreg  = st_q.bank[next_idx*SAMPLE_W +: SAMPLE_W];
                end else begin
                    st_d.mode  = MODE_IDLE;
                    st_d.eoc_n = 1'b1;
                    st_d.shreg = '0;
                end
            end
            if (pre_ready) st_d.eoc_n = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode   <= MODE_IDLE;
            st_q.eoc_n  <= 1'b1;
            st_q.ch     <= '0;
            st_q.bitcnt <= '0;
            st_q.shreg  <= '0;
            st_q.bank   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdo   = (st_q.mode != MODE_IDLE) ? st_q.shreg[SAMPLE_W-1] : 1'b0;
    assign eoc_n = st_q.eoc_n;

    assert_eoc_low_on_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && scan_on) |=> !eoc_n);

    assert_restart_bitcnt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && scan_on) |=> (st_q.bitcnt == LAST_BIT) && (st_q.mode == MODE_SCAN));

    assert_hold_when_deselected_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && !res_valid && !rd_req) |=> $stable(sdo));

    assert_early_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_ready && !res_valid) |=> eoc_n);

    assert_idle_flag_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_IDLE) |-> eoc_n);

    assert_read_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && scan_on && !res_valid && (st_q.mode == MODE_IDLE)) |=> !sdo);
endmodule

// File: rtl/adc_scan_streamer.sv
module adc_scan_streamer #(
    parameter int unsigned NUM_CH   = 4,
    parameter int unsigned SAMPLE_W = 16,
    localparam int unsigned BANK_W  = NUM_CH * SAMPLE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_CH-1:0]   chan_en,
    input  logic [BANK_W-1:0]   samples,
    input  logic                res_valid,
    input  logic                pre_ready,
    input  logic                sclk,
    input  logic                cs_n,
    input  logic                rd_req,
    input  logic [SAMPLE_W-1:0] rd_word,
    output logic                sdo,
    output logic                eoc_n
);
    logic sclk_rise;

    scan_sclk_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .sclk_rise (sclk_rise)
    );

    scan_sequencer #(
        .NUM_CH   (NUM_CH),
        .SAMPLE_W (SAMPLE_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .chan_en   (chan_en),
        .samples   (samples),
        .res_valid (res_valid),
        .pre_ready (pre_ready),
        .sclk_rise (sclk_rise),
        .cs_n      (cs_n),
        .rd_req    (rd_req),
        .rd_word   (rd_word),
        .sdo       (sdo),
        .eoc_n     (eoc_n)
    );
endmodule

// File: tb/adc_scan_streamer_bench.sv
`timescale 1ns/1ps
module adc_scan_streamer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  chan_en = '0;
    logic [63:0] samples = '0;
    logic        res_valid = 1'b0, pre_ready = 1'b0, sclk = 1'b0, cs_n = 1'b0, rd_req = 1'b0;
    logic [15:0] rd_word = '0;
    logic        sdo, eoc_n;

    always #2.5 clk = ~clk;

    adc_scan_streamer u_adc_scan_streamer (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .samples(samples),
        .res_valid(res_valid), .pre_ready(pre_ready), .sclk(sclk), .cs_n(cs_n),
        .rd_req(rd_req), .rd_word(rd_word), .sdo(sdo), .eoc_n(eoc_n)
    );

    typedef struct { logic s; logic e; string tag; } sb_item_t;
    sb_item_t sb[$];
    event     chk_ev;
    int       n_cmp = 0, n_bad = 0;
    logic     bitq[$];
    logic     exp_eoc = 1'b1;
    logic [15:0] samp [4];

    task automatic drain();
        while (sb.size() > 0) begin
            sb_item_t it = sb.pop_front();
            n_cmp++;
            if (sdo !== it.s || eoc_n !== it.e) begin
                n_bad++;
                $display("FAIL %s: sdo/eoc_n actual %b/%b expected %b/%b", it.tag, sdo, eoc_n, it.s, it.e);
            end
        end
    endtask

    initial forever begin
        @(chk_ev);
        drain();
    end

    task automatic expect_now(logic s, logic e, string tag);
        sb.push_back('{s: s, e: e, tag: tag});
        -> chk_ev;
        #0 drain();
    endtask

    function automatic logic cur_bit();
        return (bitq.size() > 0) ? bitq[0] : 1'b0;
    endfunction

    function automatic logic cur_eoc();
        return (bitq.size() > 0) ? exp_eoc : 1'b1;
    endfunction

    task automatic set_samples(logic [15:0] salt);
        samp[0] = 16'hA5C3 ^ salt; samp[1] = 16'h3C96 ^ salt;
        samp[2] = 16'hF00F ^ salt; samp[3] = 16'h8421 ^ salt;
        samples = {samp[3], samp[2], samp[1], samp[0]};
    endtask

    task automatic build_stream(logic [3:0] m);
        bitq.delete();
        for (int c = 0; c < 4; c++)
            if (m[c]) for (int b = 15; b >= 0; b--) bitq.push_back(samp[c][b]);
    endtask

    task automatic strobe(logic [3:0] m, logic pre);
        chan_en = m; res_valid = 1'b1; pre_ready = pre;
        @(negedge clk);
        res_valid = 1'b0; pre_ready = 1'b0;
        build_stream(m);
        exp_eoc = (m == 4'd0);
    endtask

    task automatic tick();
        sclk = 1'b1; @(negedge clk);
        sclk = 1'b0; @(negedge clk);
        if (bitq.size() > 0) void'(bitq.pop_front());
    endtask

    task automatic ticks_check(int n, string tag);
        for (int i = 0; i < n; i++) begin
            tick();
            expect_now(cur_bit(), cur_eoc(), tag);
        end
    endtask

    task automatic finish_run();
        drain();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual still running, expected finished");
        finish_run();
    end

    initial begin
        set_samples(16'h0000);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_now(1'b0, 1'b1, "R1 reset");
        tick(); tick();
        expect_now(1'b0, 1'b1, "R1 clocks while idle");

        // R2 R3 R4 R6: channels A and C
        strobe(4'b0101, 1'b0);
        expect_now(cur_bit(), 1'b0, "R2 first MSB");
        ticks_check(31, "R3 R4 bit stream A,C");
        tick();
        expect_now(1'b0, 1'b1, "R6 frame end");

        // R4 all channels
        set_samples(16'h5A5A);
        strobe(4'b1111, 1'b0);
        expect_now(cur_bit(), 1'b0, "R4 first MSB all");
        ticks_check(64, "R4 all channels");

        // R5 chip-select gap in channel D only
        strobe(4'b1000, 1'b0);
        expect_now(cur_bit(), 1'b0, "R2 first MSB D");
        ticks_check(5, "R3 D head");
        cs_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            sclk = 1'b1; @(negedge clk); sclk = 1'b0; @(negedge clk);
        end
        expect_now(cur_bit(), 1'b0, "R5 held while deselected");
        cs_n = 1'b0;
        ticks_check(11, "R5 resume");
        expect_now(1'b0, 1'b1, "R6 end after gap");

        // R8 mask zero ignores results
        strobe(4'b0000, 1'b0);
        expect_now(1'b0, 1'b1, "R8 result ignored");
        tick();
        expect_now(1'b0, 1'b1, "R8 still idle");

        // R7 early release mid-frame
        set_samples(16'h1234);
        strobe(4'b0011, 1'b0);
        ticks_check(4, "R3 pre-release bits");
        pre_ready = 1'b1; @(negedge clk); pre_ready = 1'b0;
        exp_eoc = 1'b1;
        expect_now(cur_bit(), 1'b1, "R7 eoc released");
        ticks_check(28, "R7 shifting continues");

        // R9 restart with sclk rise in the same cycle
        set_samples(16'h0F0F);
        strobe(4'b0110, 1'b0);
        ticks_check(7, "R3 before restart");
        set_samples(16'hC3C3);
        chan_en = 4'b0110; res_valid = 1'b1; sclk = 1'b1;
        @(negedge clk);
        res_valid = 1'b0; sclk = 1'b0;
        build_stream(4'b0110); exp_eoc = 1'b0;
        expect_now(cur_bit(), 1'b0, "R9 restart MSB");
        @(negedge clk);
        ticks_check(32, "R9 new set stream");

        // R10 read request with scan off
        chan_en = 4'b0000; rd_word = 16'hB00D; rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        bitq.delete();
        for (int b = 15; b >= 0; b--) bitq.push_back(rd_word[b]);
        exp_eoc = 1'b1;
        expect_now(cur_bit(), 1'b1, "R10 read MSB");
        ticks_check(16, "R10 read word");

        // R11 read request ignored with scan on
        chan_en = 4'b0001; rd_word = 16'hFFFF; rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        expect_now(1'b0, 1'b1, "R11 read ignored");
        tick();
        expect_now(1'b0, 1'b1, "R11 no shift out");

        // R12 result and early release together
        set_samples(16'h8001);
        strobe(4'b0001, 1'b1);
        expect_now(cur_bit(), 1'b0, "R12 result wins");
        ticks_check(16, "R12 frame completes");

        finish_run();
    end
endmodule